// File: doc/BRIEF.md
# PHY Management Register Controller

This block is the register side of a station-management port. A host issues single-word register accesses. One register holds a clock divisor and an enable bit. A second register holds a 16-bit value to send. A third holds the last value fetched. Writing the fourth, the command register, with its go bit set carries out a PHY register transfer at once. The command names the PHY bus address, the PHY register and the direction. No serial bit timing is modelled: each transfer finishes in the same cycle that the command is written.

A behavioural PHY responder sits at a bus address set by a parameter. It keeps a file of 16-bit registers. Four of its registers do not read back the stored value. Instead they build status, link-partner and speed/duplex words from the advertisement register and from the `link_up` input. A fetch from any other bus address returns all ones in the low 16 bits.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: Host selects are 0 = control, 1 = command, 2 = send data, 3 = fetched data. `req_ready` is high from the first clock after reset. An accepted read (`req_valid && req_ready && !req_write`) gives `rsp_valid` with `rsp_rdata` one cycle later. An accepted write gives no response.
- R2: Command fields are: bits 28:24 PHY bus address, bits 20:16 PHY register, bits 15:14 opcode, bit 11 go. A command with go clear transfers nothing.
- R3: A read of the command register returns the stored command word with bit 7 forced to 1, meaning ready.
- R4: Opcode 1 with go set copies bits 15:0 of the send-data register into the addressed PHY register, but only if the bus address equals `PHY_BUS_ADDR`. A write to any other bus address changes nothing.
- R5: Opcode 2 with go set loads the fetched-data register with the PHY register value, zero-extended. When no PHY answers at that bus address, the value loaded is 0x0000FFFF.
- R6: Opcodes 0 and 3 with go set pulse `op_invalid` for one cycle and leave every register unchanged.
- R7: Any PHY register write clears bits 15 and 9 of PHY register 0, including the write that targets register 0 itself.
- R8: The control register keeps only bits 6:0: bit 6 is the enable and bits 5:0 are the divisor. A write that sets the enable with a zero divisor pulses `cfg_warn` for one cycle.
- R9: After reset, PHY registers 0, 2, 3 and 4 read 0x3100, 0x0300, 0xE400 and 0x01E1. The other stored registers read 0.
- R10: PHY register 5 reads as 0x4000 OR (register 4 AND 0x01E0) OR 0x0001.
- R11: PHY register 1 reads 0x782E while `link_up` is high and 0 while it is low. PHY register 17 always reads 0x8000.
- R12: While `link_up` is high, PHY register 18 has bit 10 set if register 4 bit 7 or bit 8 is set, and bit 11 set if register 4 bit 6 or bit 8 is set. Its other bits are 0. While `link_up` is low, it reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Link state seen by the PHY responder |
| req_valid | input | 1 | Host access request |
| req_ready | output | 1 | Access can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 2 | Register select |
| req_wdata | input | BUS_W | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | BUS_W | Read data |
| op_invalid | output | 1 | Pulse: unsupported opcode was issued |
| cfg_warn | output | 1 | Pulse: enable was set with a zero divisor |

## Verification
The bench uses the default parameters: a 32-bit host word, a PHY present at bus address 7, and 32 PHY registers. With these values every fabricated register (1, 5, 17, 18) can be reached. The bench also sends random bus addresses, so most of them fall on the empty addresses and exercise the all-ones path. Random PHY writes also land on the fabricated registers, which shows that their stored values are hidden. Random toggling of `link_up` reaches both forms of registers 1 and 18.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

   typedef enum logic [1:0] {
      SEL_CTRL  = 2'd0,
      SEL_CMD   = 2'd1,
      SEL_WDATA = 2'd2,
      SEL_RDATA = 2'd3
   } reg_sel_e;

   typedef enum logic [1:0] {
      OP_RSVD0 = 2'd0,
      OP_WRITE = 2'd1,
      OP_READ  = 2'd2,
      OP_RSVD3 = 2'd3
   } mgmt_op_e;

   typedef struct packed {
      logic [4:0] phy;
      logic [4:0] regn;
      logic [1:0] op;
      logic       go;
   } mgmt_cmd_t;

   localparam int READY_BIT = 7;

   function automatic mgmt_cmd_t decode_cmd(input logic [31:0] w);
      mgmt_cmd_t c;
      c.phy  = w[28:24];
      c.regn = w[20:16];
      c.op   = w[15:14];
      c.go   = w[11];
      return c;
   endfunction

endpackage

// File: rtl/mdio_phy_model.sv
module mdio_phy_model #(
   parameter int REG_AW = 5,
   parameter int DW     = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              link_up,
   input  logic              we,
   input  logic [REG_AW-1:0] wr_reg,
   input  logic [DW-1:0]     wr_data,
   input  logic [REG_AW-1:0] rd_reg,
   output logic [DW-1:0]     rd_data
);
   localparam int NREG = 1 << REG_AW;
   localparam logic [DW-1:0] CLR_MASK = DW'(16'h8200);

   initial begin
      if (NREG < 19) $error("PHY register file too small for fabricated registers");
      if (DW != 16) $error("PHY data width must be 16");
   end

   logic [DW-1:0] regs_q [NREG];

   function automatic logic [DW-1:0] reset_val(input int i);
      case (i)
         0:       return DW'(16'h3100);
         2:       return DW'(16'h0300);
         3:       return DW'(16'hE400);
         4:       return DW'(16'h01E1);
         default: return '0;
      endcase
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) regs_q[i] <= reset_val(i);
      end else if (we) begin
         for (int i = 1; i < NREG; i++)
            if (wr_reg == REG_AW'(i)) regs_q[i] <= wr_data;
         regs_q[0] <= ((wr_reg == '0) ? wr_data : regs_q[0]) & ~CLR_MASK;
      end
   end

   logic [DW-1:0] adv;
   logic          spd100, fdx;
   assign adv    = regs_q[4];
   assign spd100 = adv[7] | adv[8];
   assign fdx    = adv[6] | adv[8];

   always_comb begin
      case (rd_reg)
         REG_AW'(1):  rd_data = link_up ? DW'(16'h782E) : '0;
         REG_AW'(5):  rd_data = DW'(16'h4000) | (adv & DW'(16'h01E0)) | DW'(1);
         REG_AW'(17): rd_data = DW'(16'h8000);
         REG_AW'(18): rd_data = link_up ? DW'({4'b0, fdx, spd100, 10'b0}) : '0;
         default:     rd_data = regs_q[rd_reg];
      endcase
   end

   // R7: control-register reset and autoneg-restart bits never survive a write
   a_r7_bmcr_clear: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (regs_q[0][15] == 1'b0 && regs_q[0][9] == 1'b0));

endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
   import mdio_mgmt_pkg::*;
#(
   parameter int BUS_W  = 32,
   parameter int PHY_DW = 16,
   parameter int DIV_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_fire,
   input  logic              req_write,
   input  logic [1:0]        req_sel,
   input  logic [BUS_W-1:0]  req_wdata,
   input  logic              phy_hit,
   input  logic [PHY_DW-1:0] phy_rd_data,
   output logic [4:0]        cmd_phy,
   output logic [4:0]        cmd_reg,
   output logic              phy_we,
   output logic [PHY_DW-1:0] phy_wdata,
   output logic              rsp_valid,
   output logic [BUS_W-1:0]  rsp_rdata,
   output logic              op_invalid,
   output logic              cfg_warn
);
   localparam int CTRL_W = DIV_W + 1;
   localparam int EN_BIT = DIV_W;

   initial begin
      if (BUS_W < 32) $error("host word must hold a full command");
      if (PHY_DW > BUS_W) $error("PHY word wider than host word");
   end

   mgmt_cmd_t         dec;
   logic              cmd_wr;
   logic [CTRL_W-1:0] ctrl_q;
   logic [BUS_W-1:0]  cmd_q, wdata_q, rdata_q;

   assign dec       = decode_cmd(req_wdata[31:0]);
   assign cmd_wr    = req_fire && req_write && (req_sel == SEL_CMD);
   assign cmd_phy   = dec.phy;
   assign cmd_reg   = dec.regn;
   assign phy_we    = cmd_wr && dec.go && (dec.op == OP_WRITE) && phy_hit;
   assign phy_wdata = wdata_q[PHY_DW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q     <= '0;
         cmd_q      <= '0;
         wdata_q    <= '0;
         rdata_q    <= '0;
         rsp_valid  <= 1'b0;
         rsp_rdata  <= '0;
         op_invalid <= 1'b0;
         cfg_warn   <= 1'b0;
      end else begin
         rsp_valid  <= 1'b0;
         op_invalid <= 1'b0;
         cfg_warn   <= 1'b0;
         if (req_fire && req_write) begin
            case (req_sel)
               SEL_CTRL: begin
                  ctrl_q   <= req_wdata[CTRL_W-1:0];
                  cfg_warn <= req_wdata[EN_BIT] && (req_wdata[DIV_W-1:0] == '0);
               end
               SEL_CMD: begin
                  cmd_q <= req_wdata;
                  if (dec.go) begin
                     if (dec.op == OP_READ)
                        rdata_q <= BUS_W'(phy_hit ? phy_rd_data : {PHY_DW{1'b1}});
                     else if (dec.op != OP_WRITE)
                        op_invalid <= 1'b1;
                  end
               end
               SEL_WDATA: wdata_q <= req_wdata;
               default:   rdata_q <= req_wdata;
            endcase
         end else if (req_fire) begin
            rsp_valid <= 1'b1;
            case (req_sel)
               SEL_CTRL:  rsp_rdata <= BUS_W'(ctrl_q);
               SEL_CMD:   rsp_rdata <= cmd_q | (BUS_W'(1) << READY_BIT);
               SEL_WDATA: rsp_rdata <= wdata_q;
               default:   rsp_rdata <= rdata_q;
            endcase
         end
      end
   end

   a_r1_read_response: assert property (@(posedge clk) disable iff (!rst_n)
      (req_fire && !req_write) |=> rsp_valid);
   a_r1_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (req_fire && req_write) |=> !rsp_valid);
   a_r3_ready_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (req_fire && !req_write && req_sel == SEL_CMD) |=> rsp_rdata[READY_BIT]);
   a_r8_ctrl_narrow: assert property (@(posedge clk) disable iff (!rst_n)
      (req_fire && !req_write && req_sel == SEL_CTRL) |=> (rsp_rdata[BUS_W-1:CTRL_W] == '0));
   a_r8_warn_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (req_fire && req_write && req_sel == SEL_CTRL && req_wdata[EN_BIT]
       && req_wdata[DIV_W-1:0] == '0) |=> cfg_warn);
   a_r5_absent_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && dec.go && dec.op == OP_READ && !phy_hit) |=> (rdata_q == BUS_W'(32'hFFFF)));
   a_r6_invalid_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && dec.go && (dec.op == OP_RSVD0 || dec.op == OP_RSVD3)) |=> op_invalid);
   a_r6_invalid_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && dec.go && (dec.op == OP_RSVD0 || dec.op == OP_RSVD3)) |=> $stable(rdata_q));

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl #(
   parameter int         BUS_W        = 32,
   parameter int         PHY_REG_AW   = 5,
   parameter int         PHY_DW       = 16,
   parameter int         DIV_W        = 6,
   parameter bit         PHY_PRESENT  = 1'b1,
   parameter logic [4:0] PHY_BUS_ADDR = 5'd7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             link_up,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic             req_write,
   input  logic [1:0]       req_sel,
   input  logic [BUS_W-1:0] req_wdata,
   output logic             rsp_valid,
   output logic [BUS_W-1:0] rsp_rdata,
   output logic             op_invalid,
   output logic             cfg_warn
);
   initial begin
      if (PHY_REG_AW != 5) $error("command carries a 5-bit PHY register field");
      if (DIV_W != 6) $error("divisor must fill bits 5:0 below the enable");
   end

   logic              ready_q, req_fire, phy_hit, phy_we;
   logic [4:0]        cmd_phy, cmd_reg;
   logic [PHY_DW-1:0] phy_wdata, phy_rd_data;

   always_ff @(posedge clk) begin
      if (!rst_n) ready_q <= 1'b0;
      else        ready_q <= 1'b1;
   end
   assign req_ready = ready_q;
   assign req_fire  = req_valid && ready_q;
   assign phy_hit   = PHY_PRESENT && (cmd_phy == PHY_BUS_ADDR);

   mdio_reg_bank #(.BUS_W(BUS_W), .PHY_DW(PHY_DW), .DIV_W(DIV_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .req_fire(req_fire), .req_write(req_write),
      .req_sel(req_sel), .req_wdata(req_wdata), .phy_hit(phy_hit),
      .phy_rd_data(phy_rd_data), .cmd_phy(cmd_phy), .cmd_reg(cmd_reg),
      .phy_we(phy_we), .phy_wdata(phy_wdata), .rsp_valid(rsp_valid),
      .rsp_rdata(rsp_rdata), .op_invalid(op_invalid), .cfg_warn(cfg_warn)
   );

   generate
      if (PHY_PRESENT) begin : g_phy
         mdio_phy_model #(.REG_AW(PHY_REG_AW), .DW(PHY_DW)) u_phy (
            .clk(clk), .rst_n(rst_n), .link_up(link_up), .we(phy_we),
            .wr_reg(cmd_reg), .wr_data(phy_wdata), .rd_reg(cmd_reg),
            .rd_data(phy_rd_data)
         );
      end else begin : g_nophy
         assign phy_rd_data = '1;
      end
   endgenerate

   a_r1_ready_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> req_ready);

endmodule

// File: tb/sim_mdio_mgmt_ctrl.sv
module sim_mdio_mgmt_ctrl;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        link_up = 1'b1;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [1:0]  req_sel = '0;
   logic [31:0] req_wdata = '0;
   logic        req_ready, rsp_valid, op_invalid, cfg_warn;
   logic [31:0] rsp_rdata;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [15:0] m [32];

   always #(CLK_PERIOD/2) clk = ~clk;

   mdio_mgmt_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .link_up(link_up), .req_valid(req_valid),
      .req_ready(req_ready), .req_write(req_write), .req_sel(req_sel),
      .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .op_invalid(op_invalid), .cfg_warn(cfg_warn)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] cmd(input logic [4:0] phy, input logic [4:0] r,
                                       input logic [1:0] op, input logic go);
      return {3'b0, phy, 3'b0, r, op, 2'b0, go, 11'b0};
   endfunction

   function automatic logic [15:0] exp_phy(input logic [4:0] n);
      logic sp, dx;
      sp = m[4][7] | m[4][8];
      dx = m[4][6] | m[4][8];
      case (n)
         5'd1:    return link_up ? 16'h782E : 16'h0;
         5'd5:    return 16'h4000 | (m[4] & 16'h01E0) | 16'h1;
         5'd17:   return 16'h8000;
         5'd18:   return link_up ? {4'b0, dx, sp, 10'b0} : 16'h0;
         default: return m[n];
      endcase
   endfunction

   task automatic bus_write(input logic [1:0] sel, input logic [31:0] d);
      req_valid = 1; req_write = 1; req_sel = sel; req_wdata = d;
      @(posedge clk); @(negedge clk);
      req_valid = 0; req_write = 0;
   endtask

   task automatic bus_read(input logic [1:0] sel, output logic [31:0] d);
      req_valid = 1; req_write = 0; req_sel = sel;
      @(posedge clk); @(negedge clk);
      req_valid = 0;
      chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'h1);
      d = rsp_rdata;
   endtask

   task automatic phy_write(input logic [4:0] a, input logic [4:0] r, input logic [15:0] d);
      bus_write(2'd2, {16'h0, d});
      bus_write(2'd1, cmd(a, r, 2'd1, 1'b1));
      if (a == 5'd7) begin
         m[r] = d;
         m[0] = m[0] & ~16'h8200;
      end
   endtask

   task automatic phy_read(input logic [4:0] a, input logic [4:0] r, output logic [31:0] d);
      bus_write(2'd1, cmd(a, r, 2'd2, 1'b1));
      bus_read(2'd3, d);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'd1234));
      for (int i = 0; i < 32; i++) m[i] = 16'h0;
      m[0] = 16'h3100; m[2] = 16'h0300; m[3] = 16'hE400; m[4] = 16'h01E1;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 ready after reset", {31'b0, req_ready}, 32'h1);
      bus_read(2'd0, v); chk("R8 ctrl reset", v, 32'h0);
      bus_read(2'd1, v); chk("R3 cmd reset shows ready", v, 32'h80);
      bus_read(2'd3, v); chk("R5 rdata reset", v, 32'h0);

      // R9 reset values
      phy_read(5'd7, 5'd0, v); chk("R9 reg0", v, 32'h3100);
      phy_read(5'd7, 5'd2, v); chk("R9 reg2", v, 32'h0300);
      phy_read(5'd7, 5'd3, v); chk("R9 reg3", v, 32'hE400);
      phy_read(5'd7, 5'd4, v); chk("R9 reg4", v, 32'h01E1);
      phy_read(5'd7, 5'd9, v); chk("R9 other", v, 32'h0);
      // R3 readback of last command
      bus_read(2'd1, v); chk("R3 cmd readback", v, cmd(5'd7, 5'd9, 2'd2, 1'b1) | 32'h80);
      // R11
      phy_read(5'd7, 5'd1, v); chk("R11 reg1 link up", v, 32'h782E);
      phy_read(5'd7, 5'd17, v); chk("R11 reg17", v, 32'h8000);
      // R10
      phy_read(5'd7, 5'd5, v); chk("R10 reg5", v, 32'h41E1);
      // R12 advertisement patterns
      phy_write(5'd7, 5'd4, 16'h0040); phy_read(5'd7, 5'd18, v); chk("R12 10 full", v, 32'h0800);
      phy_write(5'd7, 5'd4, 16'h0080); phy_read(5'd7, 5'd18, v); chk("R12 100 half", v, 32'h0400);
      phy_write(5'd7, 5'd4, 16'h0100); phy_read(5'd7, 5'd18, v); chk("R12 100 full", v, 32'h0C00);
      phy_write(5'd7, 5'd4, 16'h0020); phy_read(5'd7, 5'd18, v); chk("R12 none", v, 32'h0);
      phy_read(5'd7, 5'd5, v); chk("R10 reg5 after adv write", v, 32'h4021);
      phy_write(5'd7, 5'd4, 16'h01E1);
      link_up = 0;
      phy_read(5'd7, 5'd1, v); chk("R11 reg1 link down", v, 32'h0);
      phy_read(5'd7, 5'd18, v); chk("R12 link down", v, 32'h0);
      link_up = 1;
      // R7
      phy_write(5'd7, 5'd0, 16'hFFFF); phy_read(5'd7, 5'd0, v); chk("R7 self write", v, 32'h7DFF);
      phy_write(5'd7, 5'd0, 16'h8200); phy_write(5'd7, 5'd0, 16'hA355);
      phy_read(5'd7, 5'd0, v); chk("R7 cleared", v, 32'h2155);
      phy_write(5'd7, 5'd6, 16'h1234); phy_read(5'd7, 5'd0, v); chk("R7 other write", v, 32'h2155);
      // R4 / R5 absent PHY
      phy_write(5'd3, 5'd6, 16'hBEEF); phy_read(5'd7, 5'd6, v); chk("R4 absent write ignored", v, 32'h1234);
      phy_read(5'd3, 5'd6, v); chk("R5 absent reads ones", v, 32'hFFFF);
      // R6 invalid ops and R2 go clear
      bus_write(2'd3, 32'hCAFE0001);
      bus_write(2'd1, cmd(5'd7, 5'd6, 2'd0, 1'b1)); chk("R6 op0 flag", {31'b0, op_invalid}, 32'h1);
      @(negedge clk); chk("R6 flag one cycle", {31'b0, op_invalid}, 32'h0);
      bus_write(2'd1, cmd(5'd7, 5'd6, 2'd3, 1'b1)); chk("R6 op3 flag", {31'b0, op_invalid}, 32'h1);
      bus_read(2'd3, v); chk("R6 rdata kept", v, 32'hCAFE0001);
      bus_write(2'd1, cmd(5'd7, 5'd6, 2'd2, 1'b0)); chk("R2 go clear no flag", {31'b0, op_invalid}, 32'h0);
      bus_read(2'd3, v); chk("R2 go clear no fetch", v, 32'hCAFE0001);
      bus_write(2'd2, 32'h0000AAAA);
      bus_write(2'd1, cmd(5'd7, 5'd6, 2'd1, 1'b0));
      phy_read(5'd7, 5'd6, v); chk("R2 go clear no write", v, 32'h1234);
      bus_read(2'd2, v); chk("R1 send data readback", v, 32'h0000AAAA);
      // R8
      bus_write(2'd0, 32'hFFFFFFC0); chk("R8 warn", {31'b0, cfg_warn}, 32'h1);
      bus_read(2'd0, v); chk("R8 keep 7 bits", v, 32'h40);
      bus_write(2'd0, 32'h00000041); chk("R8 no warn", {31'b0, cfg_warn}, 32'h0);
      bus_read(2'd0, v); chk("R8 divisor kept", v, 32'h41);
      bus_write(2'd0, 32'h00000000); chk("R8 disabled no warn", {31'b0, cfg_warn}, 32'h0);
      // write gives no response
      bus_write(2'd2, 32'h5); chk("R1 write no response", {31'b0, rsp_valid}, 32'h0);

      // random mix
      for (int it = 0; it < 400; it++) begin
         logic [4:0] a, r;
         logic [15:0] d;
         a = ($urandom % 2 == 0) ? 5'd7 : 5'($urandom);
         r = 5'($urandom);
         d = 16'($urandom);
         if ($urandom % 8 == 0) link_up = ~link_up;
         if ($urandom % 2 == 0) phy_write(a, r, d);
         else begin
            phy_read(a, r, v);
            chk((a == 5'd7) ? "R10 R11 R12 random read" : "R5 random absent",
                v, (a == 5'd7) ? {16'h0, exp_phy(r)} : 32'hFFFF);
         end
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule